// File: doc/BRIEF.md
# Open-Row DRAM Request Scheduler

This block holds a small pool of pending memory reads and writes. Every cycle it scores all pending entries at once and offers the single best one to a downstream DRAM command issuer. The issuer handshakes with ready/valid and learns from a hit flag whether the target row is already open or whether it must precharge and activate first. The scheduler keeps a per-bank record of the open row, which it updates on every issue.

Entries are ranked by a fixed scheme. Aged entries come first. Writes are forced ahead of reads when too many writes are pending. Otherwise reads come before writes and open-row hits come before misses. Ties go to the oldest entry. Accesses to the same bank, row and column keep their arrival order when either access is a write. A read behind a pending write to the same location therefore waits for that write. A read that issues produces a return pulse carrying its tag one cycle later.

Top module: `dram_req_sched`

## Requirements
- R1: After reset the block offers no request (`iss_valid`=0), accepts enqueues (`enq_ready`=1), reports no return (`ret_valid`=0), and treats every bank as closed.
- R2: When all DEPTH slots are occupied, `enq_ready` is 0 and an enqueue attempt in that state is dropped: it never appears on the issue port.
- R3: `iss_hit` is 1 exactly when the offered request's bank was last issued with the same row. Among otherwise equal entries, a row hit is offered before an older miss.
- R4: While fewer than WR_MAX writes are pending and no entry has aged, no write is offered while an issuable read is present.
- R5: Among entries of equal rank, the entry pending longest is offered first.
- R6: An entry pending at least AGE_LIMIT cycles outranks every entry that has not aged, including reads that hit an open row.
- R7: When WR_MAX or more writes are pending, the oldest best-ranked write is offered ahead of all reads that have not aged.
- R8: Two entries with equal bank, row and column, at least one of them a write, issue in arrival order. A read queued behind a write to the same location waits while other reads may pass.
- R9: A read accepted on the issue port (`iss_valid` and `iss_ready`) raises `ret_valid` for one cycle on the next cycle, with `ret_tag` equal to its tag. An accepted write raises no return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | New request present |
| enq_ready | output | 1 | A free slot exists |
| enq_write | input | 1 | 1 = write, 0 = read |
| enq_bank | input | BANK_W | Target bank |
| enq_row | input | ROW_W | Target row |
| enq_col | input | COL_W | Target column |
| enq_tag | input | TAG_W | Requester tag |
| iss_valid | output | 1 | A request is offered |
| iss_ready | input | 1 | Issuer accepts the offered request |
| iss_write | output | 1 | Offered request is a write |
| iss_hit | output | 1 | Offered row is already open in its bank |
| iss_bank | output | BANK_W | Offered bank |
| iss_row | output | ROW_W | Offered row |
| iss_col | output | COL_W | Offered column |
| iss_tag | output | TAG_W | Offered tag |
| ret_valid | output | 1 | Read return pulse |
| ret_tag | output | TAG_W | Tag of the returning read |

## Verification
The interesting collision is aging against read priority. A write that has waited past AGE_LIMIT and a freshly queued read that hits an open row are both issuable in the same cycle. The bench sets this up by holding `iss_ready` low until the write crosses the age limit, then adding the read. It expects the write to be offered first and the read second, now as a miss, because the write has moved the bank's open row. Write-forcing against a pending read hit is provoked the same way by filling the pool with WR_MAX writes behind one read.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

   // Rank flags, most significant first; the age field is appended below them.
   typedef struct packed {
      logic aged;     // pending at least AGE_LIMIT cycles
      logic forced;   // write while the write pool is at its limit
      logic is_read;  // reads before writes
      logic row_hit;  // open row before closed
   } rank_t;

   localparam int unsigned RANK_W = $bits(rank_t);

endpackage

// File: rtl/sched_bank_tbl.sv
module sched_bank_tbl #(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 8,
   parameter int NBANK  = 1 << BANK_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        upd,
   input  logic [BANK_W-1:0]           upd_bank,
   input  logic [ROW_W-1:0]            upd_row,
   output logic [NBANK-1:0]            open_vld,
   output logic [NBANK-1:0][ROW_W-1:0] open_row
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_vld <= '0;
         open_row <= '0;
      end else if (upd) begin
         open_vld[upd_bank] <= 1'b1;
         open_row[upd_bank] <= upd_row;
      end
   end

endmodule

// File: rtl/sched_pick.sv
module sched_pick
   import dram_sched_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AGE_W = 6,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]            elig,
   input  logic [DEPTH-1:0]            urg,
   input  logic [DEPTH-1:0]            is_wr,
   input  logic [DEPTH-1:0]            hit,
   input  logic [DEPTH-1:0][AGE_W-1:0] age,
   input  logic                        wr_force,
   output logic                        found,
   output logic [IDX_W-1:0]            win
);

   localparam int KW = RANK_W + AGE_W;

   logic [DEPTH-1:0][KW-1:0] key;

   for (genvar g = 0; g < DEPTH; g++) begin : g_key
      rank_t rk;
      assign rk.aged    = urg[g];
      assign rk.forced  = wr_force & is_wr[g];
      assign rk.is_read = ~is_wr[g];
      assign rk.row_hit = hit[g];
      assign key[g]     = {rk, age[g]};
   end

   // All slots compared in one pass; strict ">" leaves ties with the lower slot.
   logic [KW-1:0] best;
   always_comb begin
      found = 1'b0;
      win   = '0;
      best  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (elig[i] && (!found || key[i] > best)) begin
            found = 1'b1;
            best  = key[i];
            win   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/dram_req_sched.sv
module dram_req_sched
   import dram_sched_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 8,
   parameter int COL_W     = 4,
   parameter int TAG_W     = 4,
   parameter int AGE_W     = 6,
   parameter int AGE_LIMIT = 16,
   parameter int WR_MAX    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   output logic              enq_ready,
   input  logic              enq_write,
   input  logic [BANK_W-1:0] enq_bank,
   input  logic [ROW_W-1:0]  enq_row,
   input  logic [COL_W-1:0]  enq_col,
   input  logic [TAG_W-1:0]  enq_tag,
   output logic              iss_valid,
   input  logic              iss_ready,
   output logic              iss_write,
   output logic              iss_hit,
   output logic [BANK_W-1:0] iss_bank,
   output logic [ROW_W-1:0]  iss_row,
   output logic [COL_W-1:0]  iss_col,
   output logic [TAG_W-1:0]  iss_tag,
   output logic              ret_valid,
   output logic [TAG_W-1:0]  ret_tag
);

   localparam int NBANK = 1 << BANK_W;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [AGE_W-1:0] AGE_MAX   = {AGE_W{1'b1}};
   localparam logic [AGE_W-1:0] AGE_LIM_V = AGE_W'(AGE_LIMIT);
   localparam logic [CNT_W-1:0] WR_MAX_V  = CNT_W'(WR_MAX);

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (AGE_LIMIT < 1 || AGE_LIMIT > (1 << AGE_W) - 1) begin : g_bad_age
      $error("AGE_LIMIT must fit in AGE_W bits and be nonzero");
   end
   if (WR_MAX < 1 || WR_MAX > DEPTH) begin : g_bad_wrmax
      $error("WR_MAX must lie in 1..DEPTH");
   end

   // Slot storage
   logic [DEPTH-1:0]              slot_vld, slot_wr, slot_elig, slot_urg, slot_hit;
   logic [DEPTH-1:0][BANK_W-1:0]  slot_bank;
   logic [DEPTH-1:0][ROW_W-1:0]   slot_row;
   logic [DEPTH-1:0][COL_W-1:0]   slot_col;
   logic [DEPTH-1:0][TAG_W-1:0]   slot_tag;
   logic [DEPTH-1:0][AGE_W-1:0]   slot_age;
   logic [DEPTH-1:0][DEPTH-1:0]   slot_dep;

   logic [NBANK-1:0]              open_vld;
   logic [NBANK-1:0][ROW_W-1:0]   open_row;

   logic             pick_found;
   logic [IDX_W-1:0] win_idx;
   logic             iss_fire, enq_fire, wr_force;
   logic             free_found;
   logic [IDX_W-1:0] free_idx;
   logic [CNT_W-1:0] wr_cnt;
   logic [DEPTH-1:0] new_dep, clr_mask;

   sched_bank_tbl #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (iss_fire),
      .upd_bank (iss_bank),
      .upd_row  (iss_row),
      .open_vld (open_vld),
      .open_row (open_row)
   );

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign slot_hit[g]  = open_vld[slot_bank[g]] && (open_row[slot_bank[g]] == slot_row[g]);
      assign slot_elig[g] = slot_vld[g] && (slot_dep[g] == '0);
      assign slot_urg[g]  = slot_age[g] >= AGE_LIM_V;
   end

   assign wr_cnt   = CNT_W'($countones(slot_vld & slot_wr));
   assign wr_force = wr_cnt >= WR_MAX_V;

   sched_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
      .elig     (slot_elig),
      .urg      (slot_urg),
      .is_wr    (slot_wr),
      .hit      (slot_hit),
      .age      (slot_age),
      .wr_force (wr_force),
      .found    (pick_found),
      .win      (win_idx)
   );

   assign iss_valid = pick_found;
   assign iss_write = slot_wr[win_idx];
   assign iss_hit   = slot_hit[win_idx];
   assign iss_bank  = slot_bank[win_idx];
   assign iss_row   = slot_row[win_idx];
   assign iss_col   = slot_col[win_idx];
   assign iss_tag   = slot_tag[win_idx];
   assign iss_fire  = pick_found && iss_ready;

   // Lowest free slot
   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!slot_vld[i]) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(i);
         end
      end
   end

   assign enq_ready = free_found;
   assign enq_fire  = enq_valid && free_found;

   // Ordering hazards against entries still pending after this edge
   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         clr_mask[j] = iss_fire && (win_idx == IDX_W'(j));
         new_dep[j]  = slot_vld[j] && !clr_mask[j] &&
                       (slot_bank[j] == enq_bank) && (slot_row[j] == enq_row) &&
                       (slot_col[j] == enq_col) && (slot_wr[j] || enq_write);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_vld  <= '0;
         slot_wr   <= '0;
         slot_bank <= '0;
         slot_row  <= '0;
         slot_col  <= '0;
         slot_tag  <= '0;
         slot_age  <= '0;
         slot_dep  <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (clr_mask[i]) begin
               slot_vld[i] <= 1'b0;
            end else if (enq_fire && free_idx == IDX_W'(i)) begin
               slot_vld[i]  <= 1'b1;
               slot_wr[i]   <= enq_write;
               slot_bank[i] <= enq_bank;
               slot_row[i]  <= enq_row;
               slot_col[i]  <= enq_col;
               slot_tag[i]  <= enq_tag;
               slot_age[i]  <= '0;
               slot_dep[i]  <= new_dep;
            end else begin
               if (slot_vld[i] && slot_age[i] != AGE_MAX)
                  slot_age[i] <= slot_age[i] + 1'b1;
               slot_dep[i] <= slot_dep[i] & ~clr_mask;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ret_valid <= 1'b0;
         ret_tag   <= '0;
      end else begin
         ret_valid <= iss_fire && !iss_write;
         ret_tag   <= iss_tag;
      end
   end

endmodule

// File: rtl/dram_req_sched_chk.sv
module dram_req_sched_chk #(
   parameter int DEPTH  = 8,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 8,
   parameter int TAG_W  = 4,
   parameter int NBANK  = 1 << BANK_W
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        enq_ready,
   input logic                        iss_valid,
   input logic                        iss_ready,
   input logic                        iss_write,
   input logic [BANK_W-1:0]           iss_bank,
   input logic [ROW_W-1:0]            iss_row,
   input logic [TAG_W-1:0]            iss_tag,
   input logic                        ret_valid,
   input logic [TAG_W-1:0]            ret_tag,
   input logic [DEPTH-1:0]            slot_vld,
   input logic [DEPTH-1:0]            slot_wr,
   input logic [DEPTH-1:0]            slot_elig,
   input logic [DEPTH-1:0]            slot_urg,
   input logic                        wr_force,
   input logic [NBANK-1:0]            open_vld,
   input logic [NBANK-1:0][ROW_W-1:0] open_row
);

   logic [BANK_W-1:0] last_bank;
   logic [ROW_W-1:0]  last_row;
   always_ff @(posedge clk) begin
      last_bank <= iss_bank;
      last_row  <= iss_row;
   end

   // R2: with no free slot and nothing leaving, occupancy does not change
   assert_full_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!enq_ready && !(iss_valid && iss_ready)) |=> $stable(slot_vld));

   // R3: an accepted request leaves its row recorded as open in its bank
   assert_row_opened_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready) |=> (open_vld[last_bank] && open_row[last_bank] == last_row));

   // R4: a write is offered only when no issuable read waits, unless forced or aged
   assert_read_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_write && !wr_force && ((slot_urg & slot_elig) == '0))
      |-> ((slot_elig & ~slot_wr) == '0));

   // R9: accepted read returns its tag one cycle later
   assert_read_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready && !iss_write) |=> (ret_valid && ret_tag == $past(iss_tag)));

   // R9: accepted write produces no return
   assert_write_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready && iss_write) |=> !ret_valid);

endmodule

bind dram_req_sched dram_req_sched_chk #(
   .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .TAG_W(TAG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enq_ready (enq_ready),
   .iss_valid (iss_valid),
   .iss_ready (iss_ready),
   .iss_write (iss_write),
   .iss_bank  (iss_bank),
   .iss_row   (iss_row),
   .iss_tag   (iss_tag),
   .ret_valid (ret_valid),
   .ret_tag   (ret_tag),
   .slot_vld  (slot_vld),
   .slot_wr   (slot_wr),
   .slot_elig (slot_elig),
   .slot_urg  (slot_urg),
   .wr_force  (wr_force),
   .open_vld  (open_vld),
   .open_row  (open_row)
);

// File: tb/sim_dram_req_sched.sv
module sim_dram_req_sched;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enq_valid = 1'b0, enq_ready, enq_write = 1'b0;
   logic [1:0] enq_bank = '0;
   logic [7:0] enq_row = '0;
   logic [3:0] enq_col = '0, enq_tag = '0;
   logic       iss_valid, iss_ready = 1'b0, iss_write, iss_hit;
   logic [1:0] iss_bank;
   logic [7:0] iss_row;
   logic [3:0] iss_col, iss_tag;
   logic       ret_valid;
   logic [3:0] ret_tag;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   dram_req_sched #(.AGE_W(6), .AGE_LIMIT(40)) u0 (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_write(enq_write),
      .enq_bank(enq_bank), .enq_row(enq_row), .enq_col(enq_col), .enq_tag(enq_tag),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_write(iss_write), .iss_hit(iss_hit),
      .iss_bank(iss_bank), .iss_row(iss_row), .iss_col(iss_col), .iss_tag(iss_tag),
      .ret_valid(ret_valid), .ret_tag(ret_tag)
   );

   // {write, bank[2], row[8], col[4], tag[4], expected hit}
   localparam logic [19:0] VEC [6] = '{
      {1'b0, 2'd0, 8'd5, 4'd0, 4'd1, 1'b0},
      {1'b0, 2'd0, 8'd5, 4'd1, 4'd2, 1'b1},
      {1'b1, 2'd0, 8'd6, 4'd2, 4'd3, 1'b0},
      {1'b0, 2'd0, 8'd6, 4'd3, 4'd4, 1'b1},
      {1'b0, 2'd1, 8'd5, 4'd4, 4'd5, 1'b0},
      {1'b1, 2'd0, 8'd6, 4'd5, 4'd6, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic enq(input logic w, input logic [1:0] b, input logic [7:0] r,
                      input logic [3:0] c, input logic [3:0] t);
      @(negedge clk);
      enq_valid = 1'b1; enq_write = w; enq_bank = b; enq_row = r; enq_col = c; enq_tag = t;
      @(posedge clk);
      #1 enq_valid = 1'b0;
   endtask

   task automatic pop(output logic v, output logic [3:0] t, output logic w, output logic h);
      @(negedge clk);
      iss_ready = 1'b1;
      #1;
      v = iss_valid; t = iss_tag; w = iss_write; h = iss_hit;
      @(posedge clk);
      #1 iss_ready = 1'b0;
      if (v && !w)
         chk(ret_valid && ret_tag == t, "R9 read return", int'({ret_valid, ret_tag}), int'({1'b1, t}));
      else
         chk(!ret_valid, "R9 no return", int'(ret_valid), 0);
   endtask

   // exp_hit < 0 means the hit flag is not checked
   task automatic expect_pop(input int exp_tag, input int exp_hit, input string req);
      logic v, w, h;
      logic [3:0] t;
      pop(v, t, w, h);
      chk(v && int'(t) == exp_tag, req, v ? int'(t) : -1, exp_tag);
      if (exp_hit >= 0)
         chk(v && int'(h) == exp_hit, "R3 hit flag", int'(h), exp_hit);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset
      chk(!iss_valid, "R1 iss_valid after reset", int'(iss_valid), 0);
      chk(enq_ready, "R1 enq_ready after reset", int'(enq_ready), 1);
      chk(!ret_valid, "R1 ret_valid after reset", int'(ret_valid), 0);

      // Vector walk: one request at a time, hit flag and return (R3, R9)
      for (int k = 0; k < 6; k++) begin
         enq(VEC[k][19], VEC[k][18:17], VEC[k][16:9], VEC[k][8:5], VEC[k][4:1]);
         expect_pop(int'(VEC[k][4:1]), int'(VEC[k][0]), "R3 vector issue");
      end
      // open rows now: bank0=6, bank1=5

      // R3: hits overtake an older miss
      enq(1'b0, 2'd0, 8'd7, 4'd0, 4'd1);
      enq(1'b0, 2'd1, 8'd5, 4'd0, 4'd2);
      enq(1'b0, 2'd0, 8'd6, 4'd0, 4'd3);
      expect_pop(2, 1, "R3 first hit");
      expect_pop(3, 1, "R3 second hit");
      expect_pop(1, 0, "R3 miss last");

      // R4: younger read goes before older write
      enq(1'b1, 2'd2, 8'd1, 4'd0, 4'd4);
      enq(1'b0, 2'd3, 8'd1, 4'd0, 4'd5);
      expect_pop(5, 0, "R4 read before write");
      expect_pop(4, 0, "R4 write after read");

      // R7: four pending writes force one out ahead of a read hit
      enq(1'b1, 2'd2, 8'd2, 4'd1, 4'd6);
      enq(1'b1, 2'd2, 8'd3, 4'd1, 4'd7);
      enq(1'b1, 2'd2, 8'd4, 4'd1, 4'd8);
      enq(1'b1, 2'd2, 8'd5, 4'd1, 4'd9);
      enq(1'b0, 2'd3, 8'd1, 4'd1, 4'd10);
      expect_pop(6, 0, "R7 forced write");
      expect_pop(10, 1, "R7 read once below limit");
      expect_pop(7, -1, "R7 write drain");
      expect_pop(8, -1, "R7 write drain");
      expect_pop(9, -1, "R7 write drain");

      // R8: read behind same-location write waits; unrelated read passes
      enq(1'b1, 2'd3, 8'd1, 4'd3, 4'd11);
      enq(1'b0, 2'd3, 8'd1, 4'd3, 4'd12);
      enq(1'b0, 2'd3, 8'd1, 4'd4, 4'd13);
      expect_pop(13, 1, "R8 free read passes");
      expect_pop(11, 1, "R8 write first");
      expect_pop(12, 1, "R8 dependent read last");

      // R2 and R5: fill all eight slots with equal-rank reads
      for (int k = 0; k < 8; k++) enq(1'b0, 2'd1, 8'd5, 4'(k), 4'(k));
      @(negedge clk);
      chk(!enq_ready, "R2 enq_ready when full", int'(enq_ready), 0);
      enq(1'b0, 2'd1, 8'd5, 4'd9, 4'd15);
      for (int k = 0; k < 8; k++) expect_pop(k, 1, "R5 oldest first");
      @(negedge clk);
      chk(!iss_valid, "R2 dropped enqueue absent", int'(iss_valid), 0);

      // R6: aged write beats a fresh read hit (bank0 open row 7)
      enq(1'b1, 2'd0, 8'd9, 4'd0, 4'd14);
      repeat (45) @(posedge clk);
      enq(1'b0, 2'd0, 8'd7, 4'd0, 4'd1);
      expect_pop(14, 0, "R6 aged write first");
      expect_pop(1, 0, "R6 read after aged write");

      finish_run();
   end

endmodule